// File: doc/BRIEF.md
# Pulse-Swallow Divider Chain

This block is the digital core of an integer-N synthesizer's dividers. A feedback chain turns input-clock events into a feedback pulse `fp_o`. It is built from a prescaler that divides by 10 or 11, a 9-bit main counter and a 4-bit swallow counter. A separate 6-bit counter turns reference events into a comparison pulse `fc_o`. Both chains run on one system clock. Each input event is presented as a one-cycle strobe (`fin_en`, `ref_en`), so every divide ratio is counted in strobes.

The swallow counter holds the prescaler at 11 for the first A prescaler cycles of each main cycle and at 10 for the rest, so the feedback ratio is 10·(M+1)+A. A bypass setting removes the prescaler and the swallow counter, and the main counter then divides the strobes by M+1 on its own. New divisor values are normally taken only when the chain that uses them reaches terminal count, so a period is never cut short. A load-now control applies them every cycle instead. A power-down control freezes both chains without losing their count. A three-bit select routes one internal signal to a debug pin and flags a select that names more than one signal.

Top module: `fdiv_chain`

## Requirements
- R1: With bypass low, the number of `fin_en` strobes from one `fp_o` pulse to the next is 10·(M+1)+A, for M in 1..511 and A up to min(15, M+1).
- R2: With bypass low, the modulus-select signal is high during the first A prescaler cycles of each main cycle, each 11 strobes long, so it is high for 11·A clock cycles per `fp_o` period when `fin_en` is held high.
- R3: With bypass high, `fp_o` recurs every M+1 `fin_en` strobes, the value of `a_val` has no effect, and the modulus-select signal stays low.
- R4: `fc_o` recurs every R+1 `ref_en` strobes; with R = 0 every strobe yields a pulse.
- R5: `fp_o` and `fc_o` are pulses one clock wide, registered one cycle after the strobe that reaches terminal count.
- R6: With `load_now` low, new values of `m_val`, `a_val` and `bypass` take effect only after the feedback chain's next terminal count, and a new `r_val` only after the reference chain's next terminal count.
- R7: With `load_now` high, the divisor registers follow the inputs every cycle, so a smaller M ends the current feedback period early.
- R8: While `pwr_dn` is high, neither chain advances and no `fp_o` or `fc_o` pulse appears. After release, counting resumes from the held state.
- R9: `dbg_sel` is one-hot: bit 0 routes `fp_o`, bit 1 routes `fc_o` and bit 2 routes the modulus-select signal to `dbg_out`. With no bit set, `dbg_out` is low and `dbg_err` is low.
- R10: If more than one `dbg_sel` bit is set, `dbg_err` is high and `dbg_out` is held low.
- R11: During reset and right after it, `fp_o`, `fc_o`, `dbg_out` and `dbg_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fin_en | input | 1 | One strobe per input-clock event to be divided |
| ref_en | input | 1 | One strobe per reference-clock event |
| m_val | input | 9 | Main counter value M |
| a_val | input | 4 | Swallow count A |
| r_val | input | 6 | Reference counter value R |
| bypass | input | 1 | Divide by M+1 directly, with no prescaler |
| pwr_dn | input | 1 | Freeze both divider chains |
| load_now | input | 1 | Apply divisor inputs every cycle |
| dbg_sel | input | 3 | Debug route select: bit0 fp, bit1 fc, bit2 modulus select |
| fp_o | output | 1 | Feedback pulse |
| fc_o | output | 1 | Comparison pulse |
| dbg_out | output | 1 | Routed debug signal |
| dbg_err | output | 1 | More than one debug route selected |

## Verification
The assertions take the programmed values to be legal. M is at least 1 whenever bypass is set, so `fp_o` never recurs on adjacent cycles. They also take the divisor inputs as steady except across a terminal count or while `load_now` is high, so the modulus select changes only at a prescaler boundary. The stimulus changes configuration only on the falling clock edge and keeps M at 1 or above and A at no more than M+1. After each change it discards two feedback periods before it measures, so the period it checks never spans the switch-over.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  // bit positions of the debug route select
  localparam int unsigned DBG_FP_BIT = 0;
  localparam int unsigned DBG_FC_BIT = 1;
  localparam int unsigned DBG_MS_BIT = 2;
  localparam int unsigned DBG_W      = 3;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_ONE  = 2'd1,
    ROUTE_MANY = 2'd2
  } route_kind_e;

  function automatic route_kind_e classify_sel(input logic [DBG_W-1:0] sel);
    int unsigned n;
    n = 0;
    for (int i = 0; i < DBG_W; i++) n += sel[i];
    if (n == 0)      return ROUTE_NONE;
    else if (n == 1) return ROUTE_ONE;
    else             return ROUTE_MANY;
  endfunction
endpackage

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int unsigned BASE = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hold,
  input  logic mod_sel,
  output logic pre_tick
);
  localparam int unsigned PW = $clog2(BASE + 2);

  logic [PW-1:0] pc_q, pc_nx;
  logic [PW-1:0] last;

  always_comb begin
    last     = mod_sel ? PW'(BASE) : PW'(BASE - 1);
    pre_tick = en && !hold && (pc_q >= last);
    pc_nx    = pc_q;
    if (hold)          pc_nx = '0;
    else if (pre_tick) pc_nx = '0;
    else if (en)       pc_nx = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nx;
  end

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick); // R1
endmodule

// File: rtl/fdiv_swallow.sv
module fdiv_swallow #(
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           restart,
  input  logic [A_W-1:0] a_lim,
  input  logic           force_off,
  input  logic           load_now,
  output logic           mod_sel
);
  logic [A_W-1:0] a_q, a_nx;

  always_comb begin
    a_nx = a_q;
    if (restart)                  a_nx = '0;
    else if (adv && (a_q < a_lim)) a_nx = a_q + 1'b1;
    mod_sel = !force_off && (a_q < a_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_q <= '0;
    else        a_q <= a_nx;
  end

  AST_MSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(adv) && !$past(restart) && !load_now && !$past(load_now))
      |-> $stable(mod_sel)); // R2
endmodule

// File: rtl/fdiv_termcnt.sv
module fdiv_termcnt #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         term,
  output logic         pulse
);
  logic [W-1:0] cnt_q, cnt_nx;
  logic         pulse_q;

  always_comb begin
    term   = en && (cnt_q >= lim);
    cnt_nx = cnt_q;
    if (term)    cnt_nx = '0;
    else if (en) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      pulse_q <= term;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/fdiv_chain.sv
module fdiv_chain
  import fdiv_pkg::*;
#(
  parameter int unsigned M_W         = 9,
  parameter int unsigned A_W         = 4,
  parameter int unsigned R_W         = 6,
  parameter int unsigned PRE_BASE    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_en,
  input  logic             ref_en,
  input  logic [M_W-1:0]   m_val,
  input  logic [A_W-1:0]   a_val,
  input  logic [R_W-1:0]   r_val,
  input  logic             bypass,
  input  logic             pwr_dn,
  input  logic             load_now,
  input  logic [DBG_W-1:0] dbg_sel,
  output logic             fp_o,
  output logic             fc_o,
  output logic             dbg_out,
  output logic             dbg_err
);
  // reset: asserted at once, released on the clock
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rs_q[SYNC_STAGES-1];

  // divisor registers in use
  logic [M_W-1:0] act_m_q, act_m_nx;
  logic [A_W-1:0] act_a_q, act_a_nx;
  logic [R_W-1:0] act_r_q, act_r_nx;
  logic           act_byp_q, act_byp_nx;

  logic fin_g, ref_g;
  logic pre_tick, main_tick, main_term, ref_term;
  logic mod_sel, fp_q, fc_q;

  // clock enables gated by power-down
  assign fin_g     = fin_en && !pwr_dn;
  assign ref_g     = ref_en && !pwr_dn;
  assign main_tick = act_byp_q ? fin_g : pre_tick;

  always_comb begin
    act_m_nx   = act_m_q;
    act_a_nx   = act_a_q;
    act_byp_nx = act_byp_q;
    act_r_nx   = act_r_q;
    if (load_now || main_term) begin
      act_m_nx   = m_val;
      act_a_nx   = a_val;
      act_byp_nx = bypass;
    end
    if (load_now || ref_term) act_r_nx = r_val;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_m_q   <= '0;
      act_a_q   <= '0;
      act_r_q   <= '0;
      act_byp_q <= 1'b0;
    end else begin
      act_m_q   <= act_m_nx;
      act_a_q   <= act_a_nx;
      act_r_q   <= act_r_nx;
      act_byp_q <= act_byp_nx;
    end
  end

  fdiv_prescaler #(.BASE(PRE_BASE)) u_pre (
    .clk      (clk),
    .rst_n    (srst_n),
    .en       (fin_g),
    .hold     (act_byp_q),
    .mod_sel  (mod_sel),
    .pre_tick (pre_tick)
  );

  fdiv_swallow #(.A_W(A_W)) u_swallow (
    .clk       (clk),
    .rst_n     (srst_n),
    .adv       (pre_tick),
    .restart   (main_term),
    .a_lim     (act_a_q),
    .force_off (act_byp_q),
    .load_now  (load_now),
    .mod_sel   (mod_sel)
  );

  fdiv_termcnt #(.W(M_W)) u_main (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (main_tick),
    .lim   (act_m_q),
    .term  (main_term),
    .pulse (fp_q)
  );

  fdiv_termcnt #(.W(R_W)) u_ref (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (ref_g),
    .lim   (act_r_q),
    .term  (ref_term),
    .pulse (fc_q)
  );

  // debug route
  logic [DBG_W-1:0] dbg_src;
  route_kind_e      kind;

  always_comb begin
    dbg_src             = '0;
    dbg_src[DBG_FP_BIT] = fp_q;
    dbg_src[DBG_FC_BIT] = fc_q;
    dbg_src[DBG_MS_BIT] = mod_sel;
    kind                = classify_sel(dbg_sel);
    dbg_err             = (kind == ROUTE_MANY);
    dbg_out             = (kind == ROUTE_ONE) ? |(dbg_src & dbg_sel) : 1'b0;
  end

  assign fp_o = fp_q;
  assign fc_o = fc_q;

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    pwr_dn |=> (!fp_o && !fc_o)); // R8
  AST_BYP_NO_SWALLOW: assert property (@(posedge clk) disable iff (!srst_n)
    act_byp_q |-> (!mod_sel && !pre_tick)); // R3
  AST_FP_ONE_WIDE: assert property (@(posedge clk) disable iff (!srst_n)
    (fp_o && !load_now && (act_m_q != '0)) |=> !fp_o); // R5
  AST_DBG_ERR_MUTE: assert property (@(posedge clk) disable iff (!srst_n)
    dbg_err |-> !dbg_out); // R10
endmodule

// File: tb/fdiv_chain_bench.sv
module fdiv_chain_bench;
  logic       clk, rst_n, fin_en, ref_en, bypass, pwr_dn, load_now;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic [5:0] r_val;
  logic [2:0] dbg_sel;
  logic       fp_o, fc_o, dbg_out, dbg_err;

  int n_chk = 0;
  int n_bad = 0;
  int fin_gap = 1;
  int ref_gap = 3;

  fdiv_chain u_fdiv_chain (
    .clk(clk), .rst_n(rst_n), .fin_en(fin_en), .ref_en(ref_en),
    .m_val(m_val), .a_val(a_val), .r_val(r_val), .bypass(bypass),
    .pwr_dn(pwr_dn), .load_now(load_now), .dbg_sel(dbg_sel),
    .fp_o(fp_o), .fc_o(fc_o), .dbg_out(dbg_out), .dbg_err(dbg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // strobe generators, driven on the falling edge
  initial begin
    int fc_cnt = 0;
    int rc_cnt = 0;
    fin_en = 1'b0;
    ref_en = 1'b0;
    forever begin
      @(negedge clk);
      fc_cnt = (fc_cnt + 1) % fin_gap;
      rc_cnt = (rc_cnt + 1) % ref_gap;
      fin_en = (fc_cnt == 0);
      ref_en = (rc_cnt == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(input bit use_fc, output int t);
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!(use_fc ? fc_o : fp_o) && t < 20000);
  endtask

  // one full period after a pulse, counting dbg_out highs
  task automatic period(input bit use_fc, output int per, output int hi);
    int d;
    wait_pulse(use_fc, d);
    per = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      per++;
      hi += int'(dbg_out);
    end while (!(use_fc ? fc_o : fp_o) && per < 20000);
  endtask

  task automatic setup(input int m, input int a, input bit byp, input logic [2:0] sel);
    int d;
    @(negedge clk);
    m_val = 9'(m); a_val = 4'(a); bypass = byp; dbg_sel = sel;
    wait_pulse(0, d);
    wait_pulse(0, d);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; m_val = 9'd1; a_val = '0; r_val = '0; bypass = 1'b0;
    pwr_dn = 1'b0; load_now = 1'b0; dbg_sel = 3'b000;
    repeat (5) @(negedge clk);
    chk("R11 fp in reset", int'(fp_o), 0);
    chk("R11 fc in reset", int'(fc_o), 0);
    chk("R11 dbg in reset", int'(dbg_out) + int'(dbg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 outputs after release", int'(fp_o | fc_o | dbg_out | dbg_err), 0);
  endtask

  task automatic t_normal(input int m, input int a);
    int per, hi;
    setup(m, a, 1'b0, 3'b001);
    period(0, per, hi);
    chk($sformatf("R1 ratio M=%0d A=%0d", m, a), per, 10 * (m + 1) + a);
    chk("R5 fp one pulse per period", hi, 1);
  endtask

  task automatic t_swallow(input int m, input int a);
    int per, hi;
    setup(m, a, 1'b0, 3'b100);
    period(0, per, hi);
    chk($sformatf("R2 msel high cycles A=%0d", a), hi, 11 * a);
    chk("R2 period", per, 10 * (m + 1) + a);
  endtask

  task automatic t_bypass(input int m);
    int per, hi;
    setup(m, 5, 1'b1, 3'b100);
    period(0, per, hi);
    chk($sformatf("R3 bypass ratio M=%0d", m), per, m + 1);
    chk("R3 msel low in bypass", hi, 0);
  endtask

  task automatic t_ref(input int r);
    int per, hi, d;
    @(negedge clk);
    r_val = 6'(r); dbg_sel = 3'b010;
    wait_pulse(1, d);
    wait_pulse(1, d);
    period(1, per, hi);
    chk($sformatf("R4 ref ratio R=%0d", r), per, ref_gap * (r + 1));
    chk("R5 fc one pulse per period", hi, 1);
  endtask

  task automatic t_deferred(input bit now);
    int t;
    setup(20, 0, 1'b0, 3'b000);
    wait_pulse(0, t);
    repeat (30) @(negedge clk);
    m_val = 9'd5; load_now = now;
    wait_pulse(0, t);
    if (now) chk("R7 immediate load shortens period", t, 30);
    else     chk("R6 old period finishes", t, 180);
    wait_pulse(0, t);
    chk(now ? "R7 new period" : "R6 new period", t, 60);
    load_now = 1'b0;
  endtask

  task automatic t_pwrdn();
    int t, hits;
    setup(20, 0, 1'b0, 3'b000);
    wait_pulse(0, t);
    repeat (50) @(negedge clk);
    pwr_dn = 1'b1;
    hits = 0;
    repeat (300) begin
      @(negedge clk);
      hits += int'(fp_o) + int'(fc_o);
    end
    pwr_dn = 1'b0;
    chk("R8 no pulses while powered down", hits, 0);
    wait_pulse(0, t);
    chk("R8 count held across power-down", t, 160);
  endtask

  task automatic t_dbg();
    int mis, hits;
    setup(5, 0, 1'b0, 3'b001);
    mis = 0; hits = 0;
    repeat (300) begin
      @(negedge clk);
      mis  += int'(dbg_out != fp_o);
      hits += int'(dbg_out);
    end
    chk("R9 fp route mismatches", mis, 0);
    chk("R9 fp route pulses", hits, 5);
    dbg_sel = 3'b010; r_val = 6'd5;
    mis = 0;
    repeat (200) begin
      @(negedge clk);
      mis += int'(dbg_out != fc_o) + int'(dbg_err);
    end
    chk("R9 fc route mismatches", mis, 0);
    dbg_sel = 3'b000;
    hits = 0;
    repeat (200) begin
      @(negedge clk);
      hits += int'(dbg_out) + int'(dbg_err);
    end
    chk("R9 no route selected", hits, 0);
  endtask

  task automatic t_multi(input logic [2:0] sel);
    int bad;
    setup(3, 2, 1'b0, sel);
    bad = 0;
    repeat (150) begin
      @(negedge clk);
      bad += int'(!dbg_err) + int'(dbg_out);
    end
    chk($sformatf("R10 multiple select %b", sel), bad, 0);
  endtask

  initial begin
    t_reset();
    t_normal(1, 0);
    t_normal(1, 2);
    t_normal(9, 5);
    t_normal(20, 15);
    t_normal(100, 9);
    fin_gap = 2;
    begin
      int per, hi;
      setup(3, 1, 1'b0, 3'b001);
      period(0, per, hi);
      chk("R1 ratio with sparse strobes", per, 2 * 41);
    end
    fin_gap = 1;
    t_swallow(9, 3);
    t_swallow(9, 0);
    t_swallow(20, 15);
    t_bypass(1);
    t_bypass(6);
    t_bypass(50);
    t_ref(0);
    t_ref(5);
    t_ref(63);
    t_deferred(1'b0);
    t_deferred(1'b1);
    t_pwrdn();
    t_dbg();
    t_multi(3'b011);
    t_multi(3'b111);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule